// File: doc/BRIEF.md
# Configurable Logic Cell

This block models one programmable cell of a logic fabric. A 16-entry truth table turns four data inputs into one combinational result. An arithmetic option turns the cell into a one-bit full adder with a carry input and a carry output. A single storage bit sits beside the table. Configuration makes it behave as a D, T, JK or SR flip-flop. It takes its data from the table result, from the cascade input of the neighbouring cell, or, when packing is set, from a data pin directly. In the packing case the table and the storage bit serve unrelated functions.

Each of the three general outputs picks, on its own, either the unregistered table result or the stored bit. One configuration therefore gives pure combinational use, pure registered use, or both at once. A feedback option replaces table input 1 with the stored bit, which turns the cell into a counter or accumulator stage. The stored bit is always present on the cascade output, so adjacent cells can form a shift register. A synchronous load path can overwrite the stored bit. Clock, asynchronous clear and clock enable are driven directly. All configuration inputs are static fields.

Top module: `lcell_top`

## Requirements
- R1: `clr` high clears the stored bit to 0 at once, without waiting for a clock edge, and holds it at 0 while high.
- R2: With `ce` low and `clr` low, a rising clock edge leaves the stored bit unchanged, even when a load is requested.
- R3: With `cfgArith` = 0, the combinational result is `cfgTable[idx]`, where bit k of idx is table input k. Table input k is `dIn[k]`, except as R5 states. In this mode `cout` is 0.
- R4: With `cfgArith` = 1, the combinational result is in0 XOR in1 XOR `cin` and `cout` is the majority of in0, in1 and `cin`. Table inputs 2 and 3 and `cfgTable` have no effect on either output.
- R5: With `cfgFeedback` = 1, table input 1 is the stored bit instead of `dIn[1]`, in both modes.
- R6: `cfgRegMode` selects the register function: 0 is D, 1 is T, 2 is JK and 3 is SR. The primary input p is the register source (R7) and the secondary input s is `dIn[2]`. D loads p. T inverts on p = 1. JK uses J = p and K = s. SR sets on p, clears on s, and clears when both are 1. All other cases hold.
- R7: The register source is `dIn[3]` when `cfgPack` = 1. Otherwise it is `chainIn` when `cfgChainSel` = 1, and otherwise it is the combinational result.
- R8: With `ce` high, `ldEn` = 1 stores `ldData` on the next edge. This overrides the R6 function but not `clr`.
- R9: With `cfgPack` = 1, `ldEn` has no effect and the R6 function applies.
- R10: `cfgOutReg` bit 0 drives `routeOut[0]`, bit 1 drives `routeOut[1]` and bit 2 drives `localOut`. A bit value of 0 routes the combinational result and a value of 1 routes the stored bit.
- R11: `chainOut` always equals the stored bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| clr | input | 1 | Asynchronous clear, active high |
| ce | input | 1 | Clock enable |
| dIn | input | 4 | Table data inputs |
| cin | input | 1 | Carry from the previous cell |
| chainIn | input | 1 | Register cascade input |
| ldEn | input | 1 | Synchronous load request |
| ldData | input | 1 | Synchronous load value |
| cfgTable | input | 16 | Truth table, indexed by the table inputs |
| cfgArith | input | 1 | 1 selects full-adder mode |
| cfgFeedback | input | 1 | 1 feeds the stored bit into table input 1 |
| cfgPack | input | 1 | 1 feeds the register from dIn[3] and disables load |
| cfgChainSel | input | 1 | 1 feeds the register from chainIn |
| cfgRegMode | input | 2 | Register function: 0 D, 1 T, 2 JK, 3 SR |
| cfgOutReg | input | 3 | Per-output choice of stored bit (1) or combinational result (0) |
| routeOut | output | 2 | General routing outputs |
| localOut | output | 1 | Local routing output |
| chainOut | output | 1 | Register cascade output |
| cout | output | 1 | Carry to the next cell |

## Verification
Random truth tables paired with random data inputs show whether the table index is built with the correct bit order. Arithmetic runs vary `cin` with otherwise random inputs and random tables, so any leakage from inputs 2 and 3 or from the table shows up as a mismatch. Each of the four register functions runs with both p and s toggled at random, which separates hold, set, clear and toggle. Sweeps that combine feedback, cascade, packing and load with random clock enables show whether the source priority and the load gating are correct. A clear raised in the middle of a cycle shows whether the clear acts without a clock edge.

// File: rtl/lcell_pkg.sv
package lcell_pkg;

  typedef enum logic [1:0] {
    MODE_D  = 2'd0,
    MODE_T  = 2'd1,
    MODE_JK = 2'd2,
    MODE_SR = 2'd3
  } regMode_e;

  typedef enum logic [1:0] {
    SRC_LUT   = 2'd0,
    SRC_CHAIN = 2'd1,
    SRC_PACK  = 2'd2
  } regSrc_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic     hold;
    logic     load;
    regSrc_e  src;
    regMode_e mode;
    logic     useFb;
    logic     arith;
  } cellStb_t;

endpackage

// File: rtl/lcell_ctrl.sv
module lcell_ctrl
  import lcell_pkg::*;
(
  input  logic       ce,
  input  logic       ldEn,
  input  logic       cfgArith,
  input  logic       cfgFeedback,
  input  logic       cfgPack,
  input  logic       cfgChainSel,
  input  logic [1:0] cfgRegMode,
  output cellStb_t   stb
);

  always_comb begin
    stb.hold  = !ce;
    // packing takes the load control away
    stb.load  = ce && ldEn && !cfgPack;
    if (cfgPack)          stb.src = SRC_PACK;
    else if (cfgChainSel) stb.src = SRC_CHAIN;
    else                  stb.src = SRC_LUT;
    stb.mode  = regMode_e'(cfgRegMode);
    stb.useFb = cfgFeedback;
    stb.arith = cfgArith;
  end

endmodule

// File: rtl/lcell_dp.sv
module lcell_dp
  import lcell_pkg::*;
#(
  parameter int LUT_INPUTS = 4,
  parameter int FB_IDX     = 1
) (
  input  logic                       clk,
  input  logic                       clr,
  input  cellStb_t                   stb,
  input  logic [LUT_INPUTS-1:0]      dIn,
  input  logic                       cin,
  input  logic                       chainIn,
  input  logic                       ldData,
  input  logic [(1<<LUT_INPUTS)-1:0] cfgTable,
  output logic                       comb,
  output logic                       q,
  output logic                       cout
);

  localparam int SEC_IDX  = 2;
  localparam int PACK_IDX = LUT_INPUTS - 1;

  logic [LUT_INPUTS-1:0] lutIdx;
  logic qReg;
  logic sumBit, carryBit;
  logic srcBit, secBit, nextQ;

  // Table inputs, with the feedback tap on one of them
  for (genvar k = 0; k < LUT_INPUTS; k++) begin : g_idx
    if (k == FB_IDX) begin : g_fb
      assign lutIdx[k] = stb.useFb ? qReg : dIn[k];
    end else begin : g_plain
      assign lutIdx[k] = dIn[k];
    end
  end

  assign sumBit   = lutIdx[0] ^ lutIdx[1] ^ cin;
  assign carryBit = (lutIdx[0] & lutIdx[1]) | (cin & (lutIdx[0] | lutIdx[1]));
  assign comb     = stb.arith ? sumBit : cfgTable[lutIdx];
  assign cout     = stb.arith & carryBit;

  always_comb begin
    case (stb.src)
      SRC_PACK:  srcBit = dIn[PACK_IDX];
      SRC_CHAIN: srcBit = chainIn;
      default:   srcBit = comb;
    endcase
  end

  assign secBit = dIn[SEC_IDX];

  always_comb begin
    case (stb.mode)
      MODE_T:  nextQ = qReg ^ srcBit;
      MODE_JK: nextQ = (srcBit & ~qReg) | (~secBit & qReg);
      MODE_SR: nextQ = ~secBit & (srcBit | qReg);
      default: nextQ = srcBit;
    endcase
  end

  always_ff @(posedge clk or posedge clr) begin
    if (clr)           qReg <= 1'b0;
    else if (stb.hold) qReg <= qReg;
    else if (stb.load) qReg <= ldData;
    else               qReg <= nextQ;
  end

  assign q = qReg;

  AST_CLEAR_ZERO: assert property (@(posedge clk) clr |-> (qReg == 1'b0)); // R1
  AST_HOLD_NO_CE: assert property (@(posedge clk) disable iff (clr)
    stb.hold |=> (qReg == $past(qReg))); // R2
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (clr)
    stb.load |=> (qReg == $past(ldData))); // R8
  AST_T_FLIPS: assert property (@(posedge clk) disable iff (clr)
    (!stb.hold && !stb.load && stb.mode == MODE_T && srcBit) |=> (qReg != $past(qReg))); // R6
  AST_CARRY_MAJ: assert property (@(posedge clk) disable iff (clr)
    stb.arith |-> (cout == ($countones({lutIdx[0], lutIdx[1], cin}) > 1))); // R4

endmodule

// File: rtl/lcell_top.sv
module lcell_top
  import lcell_pkg::*;
#(
  parameter int LUT_INPUTS = 4,
  parameter int ROUTES     = 2
) (
  input  logic                       clk,
  input  logic                       clr,
  input  logic                       ce,
  input  logic [LUT_INPUTS-1:0]      dIn,
  input  logic                       cin,
  input  logic                       chainIn,
  input  logic                       ldEn,
  input  logic                       ldData,
  input  logic [(1<<LUT_INPUTS)-1:0] cfgTable,
  input  logic                       cfgArith,
  input  logic                       cfgFeedback,
  input  logic                       cfgPack,
  input  logic                       cfgChainSel,
  input  logic [1:0]                 cfgRegMode,
  input  logic [ROUTES:0]            cfgOutReg,
  output logic [ROUTES-1:0]          routeOut,
  output logic                       localOut,
  output logic                       chainOut,
  output logic                       cout
);

  cellStb_t stb;
  logic comb, q;
  logic [ROUTES:0] outVec;

  lcell_ctrl u_ctrl (
    .ce(ce), .ldEn(ldEn), .cfgArith(cfgArith), .cfgFeedback(cfgFeedback),
    .cfgPack(cfgPack), .cfgChainSel(cfgChainSel), .cfgRegMode(cfgRegMode),
    .stb(stb)
  );

  lcell_dp #(.LUT_INPUTS(LUT_INPUTS)) u_dp (
    .clk(clk), .clr(clr), .stb(stb), .dIn(dIn), .cin(cin), .chainIn(chainIn),
    .ldData(ldData), .cfgTable(cfgTable), .comb(comb), .q(q), .cout(cout)
  );

  // Each output picks registered or unregistered result on its own
  for (genvar i = 0; i <= ROUTES; i++) begin : g_out
    assign outVec[i] = cfgOutReg[i] ? q : comb;
  end

  assign routeOut = outVec[ROUTES-1:0];
  assign localOut = outVec[ROUTES];
  assign chainOut = q;

  AST_PACK_NO_LOAD: assert property (@(posedge clk) disable iff (clr)
    (cfgPack && ce && cfgRegMode == 2'd0) |=> (chainOut == $past(dIn[LUT_INPUTS-1]))); // R9

endmodule

// File: tb/lcell_top_test.sv
module lcell_top_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic clr = 1'b1;
  logic ce = 1'b1;
  logic [3:0] dIn = '0;
  logic cin = 1'b0, chainIn = 1'b0, ldEn = 1'b0, ldData = 1'b0;
  logic [15:0] cfgTable = '0;
  logic cfgArith = 1'b0, cfgFeedback = 1'b0, cfgPack = 1'b0, cfgChainSel = 1'b0;
  logic [1:0] cfgRegMode = 2'd0;
  logic [2:0] cfgOutReg = 3'b000;
  logic [1:0] routeOut;
  logic localOut, chainOut, cout;

  int compared = 0;
  int mismatched = 0;
  bit mq = 1'b0;
  string curReq = "R1";

  lcell_top uut (
    .clk(clk), .clr(clr), .ce(ce), .dIn(dIn), .cin(cin), .chainIn(chainIn),
    .ldEn(ldEn), .ldData(ldData), .cfgTable(cfgTable), .cfgArith(cfgArith),
    .cfgFeedback(cfgFeedback), .cfgPack(cfgPack), .cfgChainSel(cfgChainSel),
    .cfgRegMode(cfgRegMode), .cfgOutReg(cfgOutReg), .routeOut(routeOut),
    .localOut(localOut), .chainOut(chainOut), .cout(cout)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic act, input bit exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference of the combinational side
  task automatic modelComb(output bit comb, output bit co);
    bit a, b;
    int idx;
    a = dIn[0];
    b = cfgFeedback ? mq : dIn[1];
    if (cfgArith) begin
      comb = a ^ b ^ cin;
      co = ((a ? 1 : 0) + (b ? 1 : 0) + (cin ? 1 : 0)) >= 2;
    end else begin
      idx = (dIn[3] ? 8 : 0) + (dIn[2] ? 4 : 0) + (b ? 2 : 0) + (a ? 1 : 0);
      comb = cfgTable[idx];
      co = 1'b0;
    end
  endtask

  task automatic runCycle();
    bit eComb, eCo, p, s, nxt;
    #1;
    modelComb(eComb, eCo);
    check(routeOut[0], cfgOutReg[0] ? mq : eComb, {"R10 routeOut0 ", curReq});
    check(routeOut[1], cfgOutReg[1] ? mq : eComb, {"R10 routeOut1 ", curReq});
    check(localOut, cfgOutReg[2] ? mq : eComb, {"R10 localOut ", curReq});
    check(cout, eCo, {"cout ", curReq});
    check(chainOut, mq, "R11 chainOut");
    p = cfgPack ? dIn[3] : (cfgChainSel ? chainIn : eComb);
    s = dIn[2];
    if (!ce) nxt = mq;
    else if (ldEn && !cfgPack) nxt = ldData;
    else begin
      case (cfgRegMode)
        2'd0: nxt = p;
        2'd1: nxt = p ? !mq : mq;
        2'd2: nxt = (p && s) ? !mq : (p ? 1'b1 : (s ? 1'b0 : mq));
        default: nxt = s ? 1'b0 : (p ? 1'b1 : mq);
      endcase
    end
    @(posedge clk);
    #1;
    mq = clr ? 1'b0 : nxt;
    check(chainOut, mq, {"stored ", curReq});
    @(negedge clk);
  endtask

  task automatic randData();
    dIn = 4'($urandom);
    cin = 1'($urandom);
    chainIn = 1'($urandom);
    ldData = 1'($urandom);
  endtask

  task automatic randOut();
    cfgOutReg = 3'($urandom);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    mismatched++;
    $display("FAIL watchdog R1: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1 reset state
    curReq = "R1 reset";
    runCycle();
    clr = 1'b0;

    // R3 table lookup, D mode from table
    curReq = "R3";
    for (int n = 0; n < 60; n++) begin
      cfgTable = 16'($urandom); randData(); randOut();
      runCycle();
    end

    // R4 full adder
    cfgArith = 1'b1; curReq = "R4";
    for (int n = 0; n < 60; n++) begin
      cfgTable = 16'($urandom); randData(); randOut();
      runCycle();
    end

    // R5 feedback in both modes
    cfgFeedback = 1'b1; curReq = "R5 arith";
    for (int n = 0; n < 40; n++) begin randData(); randOut(); runCycle(); end
    cfgArith = 1'b0; curReq = "R5 table";
    for (int n = 0; n < 40; n++) begin
      cfgTable = 16'($urandom); randData(); randOut(); runCycle();
    end
    cfgFeedback = 1'b0;

    // R6 register functions
    for (int m = 0; m < 4; m++) begin
      cfgRegMode = 2'(m);
      curReq = $sformatf("R6 mode %0d", m);
      for (int n = 0; n < 50; n++) begin
        cfgTable = 16'($urandom); randData(); randOut(); runCycle();
      end
    end

    // R7 cascade source, shift behaviour
    cfgRegMode = 2'd0; cfgChainSel = 1'b1; curReq = "R7 chain";
    for (int n = 0; n < 40; n++) begin randData(); randOut(); runCycle(); end
    cfgChainSel = 1'b0;

    // R8 load with random enable, R2 hold
    curReq = "R8 load";
    for (int n = 0; n < 60; n++) begin
      cfgRegMode = 2'($urandom); cfgTable = 16'($urandom);
      randData(); randOut(); ldEn = 1'($urandom); ce = 1'($urandom);
      runCycle();
    end
    curReq = "R2 hold";
    ce = 1'b0; ldEn = 1'b1;
    for (int n = 0; n < 20; n++) begin randData(); runCycle(); end
    ce = 1'b1; ldEn = 1'b0;

    // R9 packing ignores load, R7 packed source
    cfgPack = 1'b1; curReq = "R9 pack";
    for (int n = 0; n < 60; n++) begin
      cfgRegMode = 2'($urandom); cfgChainSel = 1'($urandom);
      cfgTable = 16'($urandom); randData(); randOut(); ldEn = 1'($urandom);
      runCycle();
    end
    cfgPack = 1'b0; ldEn = 1'b0; cfgChainSel = 1'b0;

    // mixed sweep over everything
    curReq = "R3 mixed";
    for (int n = 0; n < 300; n++) begin
      cfgArith = 1'($urandom); cfgFeedback = 1'($urandom); cfgPack = 1'($urandom);
      cfgChainSel = 1'($urandom); cfgRegMode = 2'($urandom);
      cfgTable = 16'($urandom); randData(); randOut();
      ldEn = 1'($urandom); ce = 1'($urandom);
      runCycle();
    end

    // R1 clear without a clock edge
    cfgArith = 1'b0; cfgFeedback = 1'b0; cfgPack = 1'b0; cfgChainSel = 1'b0;
    cfgRegMode = 2'd0; ce = 1'b1; ldEn = 1'b1; ldData = 1'b1;
    curReq = "R1 setup";
    runCycle();
    ldEn = 1'b0; cfgRegMode = 2'd1; dIn = 4'h0; cfgTable = 16'h0000;
    #2 clr = 1'b1;
    #1 check(chainOut, 1'b0, "R1 async clear");
    mq = 1'b0;
    @(negedge clk);
    curReq = "R1 held";
    runCycle();
    clr = 1'b0;
    runCycle();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule